// File: doc/BRIEF.md
# Arbitration-Aware IP Checksum Accumulator

This block keeps a 16-bit end-around-carry sum of the kind used for IP header checksums. The data comes from a DMA channel that may lose the bus partway through a transfer. When the channel wins the bus, the block takes a 16-bit seed as its starting partial sum. It then adds at most one beat per clock. A beat is a 32-bit word, a 16-bit half-word or a single byte, and a byte is placed in the high or low lane according to the address LSB. When the bus is lost or the cell ends, the block emits its running sum as a one-cycle write-back, so that the channel can store the sum and pass it back as the seed later.

The control is a two-state machine. In `IDLE` the block waits for a grant, and beats or close requests are ignored. The transition `IDLE -> ACTIVE` (named LOAD) occurs on `grant_i`. It loads the seed and adds any beat that arrives in the same cycle. In `ACTIVE` each valid beat is added. The transition `ACTIVE -> IDLE` (named CLOSE) occurs on `lost_i` or `eoc_i` and starts the write-back. While in `ACTIVE` without a close request, the machine stays in `ACTIVE` (named ACCUMULATE). While in `IDLE` without a grant, it stays in `IDLE` (named WAIT). The final complement and the bus protocol belong to other blocks.

Top module: `csum_accum`

## Requirements
- R1: After reset, `sum_o` is 0, `wb_valid_o` is 0 and the block is in IDLE.
- R2: A `grant_i` in IDLE sets `sum_o` to `seed_i` on the next cycle and moves the block to ACTIVE.
- R3: A word beat (`size_i`=2) in ACTIVE adds `data_i[31:16]` and `data_i[15:0]` to the sum in a single cycle.
- R4: A half-word beat (`size_i`=1) adds `data_i[15:0]` to the sum.
- R5: A byte beat (`size_i`=0) with `addr_lsb_i`=0 adds `data_i[7:0]` zero-extended to 16 bits.
- R6: A byte beat with `addr_lsb_i`=1 adds `data_i[7:0]` shifted left by 8 bits.
- R7: Any carry out of bit 15 is added back into the low 16 bits. The fold repeats until the result fits, so a word beat with a double carry still yields a correct 16-bit value. A nonzero set of terms never folds to 0.
- R8: Each valid beat accepted in ACTIVE appears in `sum_o` on the next cycle, one beat per cycle.
- R9: `lost_i` or `eoc_i` in ACTIVE makes `wb_valid_o` high for exactly one cycle, on the next cycle. `wb_sum_o` then holds the sum, including any beat that was valid in the closing cycle, and the block returns to IDLE.
- R10: If `grant_i` and `valid_i` are high in the same IDLE cycle, the load takes priority and the beat is added to the seed.
- R11: In IDLE without a grant, beats are ignored and `sum_o` holds. `lost_i` and `eoc_i` produce no write-back.
- R12: Size code 3 adds nothing. `grant_i` while ACTIVE has no effect on the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 16 | Saved partial sum loaded on grant |
| grant_i | input | 1 | Channel has won the bus |
| lost_i | input | 1 | Channel has lost arbitration |
| eoc_i | input | 1 | End of cell transfer |
| valid_i | input | 1 | Beat present on data_i |
| size_i | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| addr_lsb_i | input | 1 | Address bit 0 for byte beats |
| data_i | input | 32 | Beat data |
| sum_o | output | 16 | Running sum |
| wb_valid_o | output | 1 | One-cycle write-back strobe |
| wb_sum_o | output | 16 | Sum to be saved on write-back |

## Verification
The assertions check the following on every cycle: the write-back strobe lasts a single cycle and follows every close, a grant loads the seed, the sum holds when idle, and the fold never turns nonzero terms into zero. Only the bench's reference model can show that the arithmetic is correct. This covers lane placement by size and address parity, the double-carry fold of word beats, a beat that coincides with a grant or a close, and the restored sum across a lost-and-regained bus.

// File: rtl/csum_pkg.sv
package csum_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } beat_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } acc_state_e;
endpackage

// File: rtl/csum_align.sv
module csum_align
    import csum_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  logic [2*SUM_W-1:0] data_i,
    input  logic [1:0]         size_i,
    input  logic               addr_lsb_i,
    input  logic               en_i,
    output logic [SUM_W-1:0]   term_hi_o,
    output logic [SUM_W-1:0]   term_lo_o
);
    localparam int LANE_W = SUM_W / 2;

    logic [LANE_W-1:0] byte_lane;
    assign byte_lane = data_i[LANE_W-1:0];

    always_comb begin
        term_hi_o = '0;
        term_lo_o = '0;
        if (en_i) begin
            unique case (beat_size_e'(size_i))
                SZ_WORD: begin
                    term_hi_o = data_i[2*SUM_W-1:SUM_W];
                    term_lo_o = data_i[SUM_W-1:0];
                end
                SZ_HALF: begin
                    term_lo_o = data_i[SUM_W-1:0];
                end
                SZ_BYTE: begin
                    if (addr_lsb_i) begin
                        term_lo_o = {byte_lane, {LANE_W{1'b0}}};
                    end else begin
                        term_lo_o = {{LANE_W{1'b0}}, byte_lane};
                    end
                end
                SZ_RSVD: begin
                    term_lo_o = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/csum_fold.sv
module csum_fold #(
    parameter int SUM_W = 16
) (
    input  logic [SUM_W-1:0] base_i,
    input  logic [SUM_W-1:0] term_a_i,
    input  logic [SUM_W-1:0] term_b_i,
    output logic [SUM_W-1:0] result_o
);
    localparam int RAW_W = SUM_W + 2;

    logic [RAW_W-1:0] raw;
    logic [SUM_W:0]   fold1;
    logic [SUM_W:0]   fold2;

    always_comb begin
        raw    = {2'b00, base_i} + {2'b00, term_a_i} + {2'b00, term_b_i};
        fold1  = {1'b0, raw[SUM_W-1:0]} + {{(SUM_W-1){1'b0}}, raw[RAW_W-1:SUM_W]};
        fold2  = {1'b0, fold1[SUM_W-1:0]} + {{SUM_W{1'b0}}, fold1[SUM_W]};
        result_o = fold2[SUM_W-1:0];
    end
endmodule

// File: rtl/csum_ctrl.sv
module csum_ctrl
    import csum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic lost_i,
    input  logic eoc_i,
    input  logic valid_i,
    output logic load_o,
    output logic add_o,
    output logic close_o,
    output logic active_o
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_i) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (lost_i || eoc_i) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        add_o    = 1'b0;
        close_o  = 1'b0;
        active_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = grant_i;
                add_o  = grant_i && valid_i;
            end
            ST_ACTIVE: begin
                active_o = 1'b1;
                add_o    = valid_i;
                close_o  = lost_i || eoc_i;
            end
        endcase
    end

    AST_CLOSE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> !active_o); // R9
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> active_o); // R2
endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         seed_i,
    input  logic                grant_i,
    input  logic                lost_i,
    input  logic                eoc_i,
    input  logic                valid_i,
    input  logic [1:0]          size_i,
    input  logic                addr_lsb_i,
    input  logic [31:0]         data_i,
    output logic [15:0]         sum_o,
    output logic                wb_valid_o,
    output logic [15:0]         wb_sum_o
);
    localparam int DATA_W = 2 * SUM_W;

    logic             load_en, add_en, close_en, active;
    logic [SUM_W-1:0] term_hi, term_lo, base, folded, sum_d;
    logic [SUM_W-1:0] sum_q, wb_sum_q;
    logic             wb_valid_q;

    csum_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant_i  (grant_i),
        .lost_i   (lost_i),
        .eoc_i    (eoc_i),
        .valid_i  (valid_i),
        .load_o   (load_en),
        .add_o    (add_en),
        .close_o  (close_en),
        .active_o (active)
    );

    csum_align #(.SUM_W(SUM_W)) u_align (
        .data_i     (data_i[DATA_W-1:0]),
        .size_i     (size_i),
        .addr_lsb_i (addr_lsb_i),
        .en_i       (add_en),
        .term_hi_o  (term_hi),
        .term_lo_o  (term_lo)
    );

    assign base = load_en ? seed_i[SUM_W-1:0] : sum_q;

    csum_fold #(.SUM_W(SUM_W)) u_fold (
        .base_i   (base),
        .term_a_i (term_hi),
        .term_b_i (term_lo),
        .result_o (folded)
    );

    always_comb begin
        sum_d = sum_q;
        if (load_en || add_en) begin
            sum_d = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q      <= '0;
            wb_valid_q <= 1'b0;
            wb_sum_q   <= '0;
        end else begin
            sum_q      <= sum_d;
            wb_valid_q <= close_en;
            if (close_en) begin
                wb_sum_q <= sum_d;
            end
        end
    end

    assign sum_o      = sum_q;
    assign wb_valid_o = wb_valid_q;
    assign wb_sum_o   = wb_sum_q;

    AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o); // R9
    AST_WB_MATCHES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (wb_sum_o == sum_o)); // R9
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !valid_i) |=> (sum_o == $past(seed_i))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !grant_i) |=> ($stable(sum_o) && !wb_valid_o)); // R11
    AST_FOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && (base != 0 || term_hi != 0 || term_lo != 0)) |-> (folded != 0)); // R7
endmodule

// File: tb/test_csum_accum.sv
module test_csum_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seed_i = '0;
    logic        grant_i = 1'b0, lost_i = 1'b0, eoc_i = 1'b0, valid_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        addr_lsb_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [15:0] sum_o, wb_sum_o;
    logic        wb_valid_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_sum = 0;
    int m_active = 0;
    int m_wbv = 0;
    int m_wbs = 0;

    always #10 clk = ~clk;

    csum_accum i_csum_accum (
        .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .grant_i(grant_i),
        .lost_i(lost_i), .eoc_i(eoc_i), .valid_i(valid_i), .size_i(size_i),
        .addr_lsb_i(addr_lsb_i), .data_i(data_i), .sum_o(sum_o),
        .wb_valid_o(wb_valid_o), .wb_sum_o(wb_sum_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int add_beat(int s, int sz, int lsb, int d);
        int t = s;
        if (sz == 2) t = t + ((d >> 16) & 'hFFFF) + (d & 'hFFFF);
        else if (sz == 1) t = t + (d & 'hFFFF);
        else if (sz == 0) t = t + (lsb ? ((d & 'hFF) << 8) : (d & 'hFF));
        while (t > 'hFFFF) t = (t & 'hFFFF) + (t >> 16);
        return t;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit g, bit l, bit e, bit v, int sz, bit lsb,
                        int d, int sd);
        grant_i = g; lost_i = l; eoc_i = e; valid_i = v;
        size_i = sz[1:0]; addr_lsb_i = lsb; data_i = d; seed_i = sd[15:0];
        @(posedge clk);
        m_wbv = 0;
        if (m_active == 0) begin
            if (g) begin
                m_sum = sd & 'hFFFF;
                if (v) m_sum = add_beat(m_sum, sz, lsb, d);
                m_active = 1;
            end
        end else begin
            if (v) m_sum = add_beat(m_sum, sz, lsb, d);
            if (l || e) begin
                m_wbv = 1;
                m_wbs = m_sum;
                m_active = 0;
            end
        end
        @(negedge clk);
        check({tag, " sum"}, int'(sum_o), m_sum);
        check({tag, " wb_valid"}, int'(wb_valid_o), m_wbv);
        if (m_wbv) check({tag, " wb_sum"}, int'(wb_sum_o), m_wbs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset sum", int'(sum_o), 0);
        check("R1 reset wb", int'(wb_valid_o), 0);
        step("R11 idle beat ignored", 0, 0, 0, 1, 1, 0, 'h1234, 0);
        step("R11 idle close no wb", 0, 1, 1, 0, 0, 0, 0, 0);
        step("R2 grant load", 1, 0, 0, 0, 0, 0, 0, 'hFFFF);
        step("R7 double carry word", 0, 0, 0, 1, 2, 0, 'hFFFF_FFFF, 0);
        step("R12 regrant ignored", 1, 0, 0, 0, 0, 0, 0, 'h0001);
        step("R3 word", 0, 0, 0, 1, 2, 0, 'h1234_5678, 0);
        step("R4 half", 0, 0, 0, 1, 1, 0, 'hABCD_8001, 0);
        step("R5 byte even", 0, 0, 0, 1, 0, 0, 'hFFFF_FF7E, 0);
        step("R6 byte odd", 0, 0, 0, 1, 0, 1, 'hFFFF_FF7E, 0);
        step("R12 size3", 0, 0, 0, 1, 3, 1, 'hFFFF_FFFF, 0);
        step("R8 no beat hold", 0, 0, 0, 0, 2, 0, 'hFFFF_FFFF, 0);
        step("R9 lost with beat", 0, 1, 0, 1, 1, 0, 'h0000_0100, 0);
        step("R9 strobe ends", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10 grant with beat", 1, 0, 0, 1, 2, 0, 'h8000_8000, 'h8000);
        step("R9 eoc", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R2 zero seed", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R7 zero stays zero", 0, 0, 0, 1, 2, 0, 0, 0);
        step("R9 eoc zero", 0, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom;
            step("R8 random", (r & 15) == 0, (r & 31) == 1, (r & 31) == 2,
                 (r >> 5) & 1, (r >> 6) & 3, (r >> 8) & 1, $urandom, $urandom);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule